// File: doc/BRIEF.md
# Paged memory map controller

This block decodes the 16-bit address bus of an 8-bit processor into selects for RAM, an I/O hole and a paged EEPROM. It holds one write-only 8-bit paging register. That register chooses the physical RAM bank seen through the lower 32K window and the EEPROM 4K page seen through the upper ROM window. It also drives a status LED whose pin is active low. The processor writes the register with an ordinary store to the latch address. The new mapping is in force from the next bus cycle, so code running from ROM can switch banks between two adjacent instructions.

The selects and physical address bits are combinational functions of the current bus address and the register contents. Only the paging register is clocked. The processor vector area always comes from the last EEPROM page, so reset and interrupt vectors do not move when software changes the ROM page. Unselected physical address outputs read as zero.

Top module: `paged_mem_ctrl`

## Requirements
- R1: With bus_valid high and bus_addr in 0x0000-0x7FFF, ram_sel is 1 and ram_addr equals {map, bus_addr[14:0]}, where map is register bits [3:0].
- R2: With bus_valid high and bus_addr in 0x8000-0xDFFF, ram_sel is 1 and ram_addr equals {4'd1, bus_addr[14:0]}, whatever map holds. Map value 1 therefore makes the two RAM windows alias one bank.
- R3: With bus_valid high and bus_addr in 0xE000-0xEFFF, io_sel is 1 and ram_sel and rom_sel are 0.
- R4: With bus_valid high and bus_addr in 0xF000-0xFFEF, rom_sel is 1 and rom_addr equals {page, bus_addr[11:0]}, where page is register bits [6:4].
- R5: With bus_valid high and bus_addr in 0xFFF0-0xFFFF, rom_sel is 1 and rom_addr equals {3'b111, bus_addr[11:0]}, whatever page holds.
- R6: A cycle with bus_valid and bus_we high and bus_addr equal to 0xEF00 loads bus_wdata into the paging register on that clock edge. The mapping seen in the following cycle uses the new value.
- R7: After reset the register holds 0x80: map 0, page 0 and the LED off (led_n = 1).
- R8: led_n follows register bit 7. Writing 1 turns the LED off and writing 0 turns it on.
- R9: Reads of 0xEF00, writes to any other address and writes with bus_valid low leave the register unchanged.
- R10: With bus_valid low, ram_sel, rom_sel and io_sel are all 0, and ram_addr and rom_addr are 0.
- R11: At most one of ram_sel, rom_sel and io_sel is 1 in any cycle. The physical address output of an unselected device is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | The bus carries an access this cycle |
| bus_we | input | 1 | The access is a write |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| ram_sel | output | 1 | RAM select |
| ram_addr | output | 19 | Physical RAM address {bank, offset} |
| rom_sel | output | 1 | EEPROM select |
| rom_addr | output | 15 | Physical EEPROM address {page, offset} |
| io_sel | output | 1 | I/O region select |
| led_n | output | 1 | Status LED, low means lit |

## Verification
The selects and physical addresses depend only on the address and the current register contents, so they are due in the same cycle the address is driven. The bench drives each access on the falling edge and samples the outputs two nanoseconds later, before the next rising edge. A register write only takes effect at the rising edge that closes its own cycle. The reference model therefore computes that cycle's expectations from the old register value and applies the write afterwards, which makes the first access after a write the one that shows the new bank, page and LED state.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

   typedef enum logic [2:0] {
      RGN_NONE   = 3'd0,
      RGN_RAM_LO = 3'd1,
      RGN_RAM_HI = 3'd2,
      RGN_IO     = 3'd3,
      RGN_ROM    = 3'd4,
      RGN_VEC    = 3'd5
   } region_e;

endpackage

// File: rtl/mmap_decode.sv
module mmap_decode
   import mmap_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] LOW_TOP   = 16'h7FFF,
   parameter logic [ADDR_W-1:0] UPPER_TOP = 16'hDFFF,
   parameter logic [ADDR_W-1:0] IO_TOP    = 16'hEFFF,
   parameter logic [ADDR_W-1:0] VEC_BASE  = 16'hFFF0
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   output region_e           rgn
);

   always_comb begin
      if (!valid)                 rgn = RGN_NONE;
      else if (addr <= LOW_TOP)   rgn = RGN_RAM_LO;
      else if (addr <= UPPER_TOP) rgn = RGN_RAM_HI;
      else if (addr <= IO_TOP)    rgn = RGN_IO;
      else if (addr < VEC_BASE)   rgn = RGN_ROM;
      else                        rgn = RGN_VEC;
   end

endmodule

// File: rtl/mmap_latch.sv
module mmap_latch #(
   parameter int                ADDR_W     = 16,
   parameter int                MAP_W      = 4,
   parameter int                PAGE_W     = 3,
   parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'hEF00,
   localparam int               DATA_W     = MAP_W + PAGE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [MAP_W-1:0]  map,
   output logic [PAGE_W-1:0] page,
   output logic              led_n
);

   localparam logic [DATA_W-1:0] RESET_VAL = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] q;
   logic              hit;

   assign hit = valid && we && (addr == LATCH_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RESET_VAL;
      else if (hit) q <= wdata;
   end

   assign map   = q[MAP_W-1:0];
   assign page  = q[MAP_W +: PAGE_W];
   assign led_n = q[DATA_W-1];

endmodule

// File: rtl/mmap_addr.sv
module mmap_addr
   import mmap_pkg::*;
#(
   parameter int  MAP_W      = 4,
   parameter int  PAGE_W     = 3,
   parameter int  RAM_OFF_W  = 15,
   parameter int  ROM_OFF_W  = 12,
   parameter int  UPPER_BANK = 1,
   parameter bit  VEC_FIXED  = 1'b1,
   localparam int RAM_PA_W   = MAP_W + RAM_OFF_W,
   localparam int ROM_PA_W   = PAGE_W + ROM_OFF_W
) (
   input  region_e              rgn,
   input  logic [RAM_OFF_W-1:0] off,
   input  logic [MAP_W-1:0]     map,
   input  logic [PAGE_W-1:0]    page,
   output logic                 ram_sel,
   output logic [RAM_PA_W-1:0]  ram_addr,
   output logic                 rom_sel,
   output logic [ROM_PA_W-1:0]  rom_addr,
   output logic                 io_sel
);

   localparam logic [MAP_W-1:0] UB = MAP_W'(UPPER_BANK);

   logic [PAGE_W-1:0]    vec_page;
   logic [ROM_OFF_W-1:0] rom_off;

   assign rom_off = off[ROM_OFF_W-1:0];

   generate
      if (VEC_FIXED) begin : g_vec_fixed
         assign vec_page = {PAGE_W{1'b1}};
      end else begin : g_vec_paged
         assign vec_page = page;
      end
   endgenerate

   always_comb begin
      ram_sel  = 1'b0;
      rom_sel  = 1'b0;
      io_sel   = 1'b0;
      ram_addr = '0;
      rom_addr = '0;
      case (rgn)
         RGN_RAM_LO: begin
            ram_sel  = 1'b1;
            ram_addr = {map, off};
         end
         RGN_RAM_HI: begin
            ram_sel  = 1'b1;
            ram_addr = {UB, off};
         end
         RGN_IO: io_sel = 1'b1;
         RGN_ROM: begin
            rom_sel  = 1'b1;
            rom_addr = {page, rom_off};
         end
         RGN_VEC: begin
            rom_sel  = 1'b1;
            rom_addr = {vec_page, rom_off};
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/paged_mem_ctrl.sv
module paged_mem_ctrl
   import mmap_pkg::*;
#(
   parameter int  ADDR_W     = 16,
   parameter int  MAP_W      = 4,
   parameter int  PAGE_W     = 3,
   parameter int  ROM_OFF_W  = 12,
   parameter int  UPPER_BANK = 1,
   parameter bit  VEC_FIXED  = 1'b1,
   localparam int DATA_W     = MAP_W + PAGE_W + 1,
   localparam int RAM_OFF_W  = ADDR_W - 1,
   localparam int RAM_PA_W   = MAP_W + RAM_OFF_W,
   localparam int ROM_PA_W   = PAGE_W + ROM_OFF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic                ram_sel,
   output logic [RAM_PA_W-1:0] ram_addr,
   output logic                rom_sel,
   output logic [ROM_PA_W-1:0] rom_addr,
   output logic                io_sel,
   output logic                led_n
);

   generate
      if (ADDR_W != 16) begin : g_bad_aw
         $error("paged_mem_ctrl: ADDR_W must be 16");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("paged_mem_ctrl: MAP_W + PAGE_W + 1 must be 8");
      end
      if (ROM_OFF_W >= RAM_OFF_W) begin : g_bad_rom
         $error("paged_mem_ctrl: ROM window must be smaller than RAM window");
      end
      if (UPPER_BANK >= (1 << MAP_W)) begin : g_bad_ub
         $error("paged_mem_ctrl: UPPER_BANK out of map range");
      end
   endgenerate

   region_e           rgn;
   logic [MAP_W-1:0]  map;
   logic [PAGE_W-1:0] page;

   mmap_decode #(
      .ADDR_W (ADDR_W)
   ) u_decode (
      .valid (bus_valid),
      .addr  (bus_addr),
      .rgn   (rgn)
   );

   mmap_latch #(
      .ADDR_W (ADDR_W),
      .MAP_W  (MAP_W),
      .PAGE_W (PAGE_W)
   ) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (bus_valid),
      .we    (bus_we),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .map   (map),
      .page  (page),
      .led_n (led_n)
   );

   mmap_addr #(
      .MAP_W      (MAP_W),
      .PAGE_W     (PAGE_W),
      .RAM_OFF_W  (RAM_OFF_W),
      .ROM_OFF_W  (ROM_OFF_W),
      .UPPER_BANK (UPPER_BANK),
      .VEC_FIXED  (VEC_FIXED)
   ) u_addr (
      .rgn      (rgn),
      .off      (bus_addr[RAM_OFF_W-1:0]),
      .map      (map),
      .page     (page),
      .ram_sel  (ram_sel),
      .ram_addr (ram_addr),
      .rom_sel  (rom_sel),
      .rom_addr (rom_addr),
      .io_sel   (io_sel)
   );

endmodule

// File: rtl/paged_mem_ctrl_chk.sv
module paged_mem_ctrl_chk #(
   parameter int  MAP_W     = 4,
   parameter int  PAGE_W    = 3,
   parameter int  ROM_OFF_W = 12,
   localparam int DATA_W    = MAP_W + PAGE_W + 1,
   localparam int RAM_PA_W  = MAP_W + 15,
   localparam int ROM_PA_W  = PAGE_W + ROM_OFF_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_valid,
   input logic                bus_we,
   input logic [15:0]         bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                ram_sel,
   input logic [RAM_PA_W-1:0] ram_addr,
   input logic                rom_sel,
   input logic [ROM_PA_W-1:0] rom_addr,
   input logic                io_sel,
   input logic                led_n
);

   logic wr_hit;
   assign wr_hit = bus_valid && bus_we && (bus_addr == 16'hEF00);

   assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_sel, rom_sel, io_sel}));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> (!ram_sel && !rom_sel && !io_sel));

   assert_io_hole_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr[15:12] == 4'hE) |-> (io_sel && !ram_sel && !rom_sel));

   assert_upper_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr >= 16'h8000 && bus_addr <= 16'hDFFF)
         |-> (ram_sel && ram_addr[RAM_PA_W-1 -: MAP_W] == MAP_W'(1)));

   assert_vec_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr[15:4] == 12'hFFF)
         |-> (rom_sel && rom_addr[ROM_PA_W-1 -: PAGE_W] == {PAGE_W{1'b1}}));

   assert_led_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (led_n == $past(bus_wdata[DATA_W-1])));

   assert_led_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(led_n));

endmodule

bind paged_mem_ctrl paged_mem_ctrl_chk #(
   .MAP_W     (MAP_W),
   .PAGE_W    (PAGE_W),
   .ROM_OFF_W (ROM_OFF_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ram_sel   (ram_sel),
   .ram_addr  (ram_addr),
   .rom_sel   (rom_sel),
   .rom_addr  (rom_addr),
   .io_sel    (io_sel),
   .led_n     (led_n)
);

// File: tb/paged_mem_ctrl_tb.sv
module paged_mem_ctrl_tb;

   localparam time CLK_P = 8ns;

   typedef struct {
      logic        ram_sel;
      logic [18:0] ram_addr;
      logic        rom_sel;
      logic [14:0] rom_addr;
      logic        io_sel;
      logic        led_n;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        ram_sel, rom_sel, io_sel, led_n;
   logic [18:0] ram_addr;
   logic [14:0] rom_addr;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   exp_t q[$];

   logic [7:0] m_reg = 8'h80;

   always #(CLK_P/2) clk = ~clk;

   paged_mem_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .ram_sel   (ram_sel),
      .ram_addr  (ram_addr),
      .rom_sel   (rom_sel),
      .rom_addr  (rom_addr),
      .io_sel    (io_sel),
      .led_n     (led_n)
   );

   function automatic exp_t model(logic v, logic [15:0] a, string tag);
      exp_t e;
      e.ram_sel = 0; e.rom_sel = 0; e.io_sel = 0;
      e.ram_addr = '0; e.rom_addr = '0;
      e.led_n = m_reg[7];
      e.tag = tag;
      if (v) begin
         if (a < 16'h8000) begin
            e.ram_sel = 1; e.ram_addr = {m_reg[3:0], a[14:0]};
         end else if (a < 16'hE000) begin
            e.ram_sel = 1; e.ram_addr = {4'd1, a[14:0]};
         end else if (a < 16'hF000) begin
            e.io_sel = 1;
         end else if (a < 16'hFFF0) begin
            e.rom_sel = 1; e.rom_addr = {m_reg[6:4], a[11:0]};
         end else begin
            e.rom_sel = 1; e.rom_addr = {3'b111, a[11:0]};
         end
      end
      return e;
   endfunction

   task automatic access(logic v, logic w, logic [15:0] a, logic [7:0] d, string tag);
      @(negedge clk);
      bus_valid = v; bus_we = w; bus_addr = a; bus_wdata = d;
      q.push_back(model(v, a, tag));
      if (v && w && a == 16'hEF00) m_reg = d;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(negedge clk) begin
      #2ns;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_cmp++;
         if (ram_sel !== e.ram_sel || ram_addr !== e.ram_addr ||
             rom_sel !== e.rom_sel || rom_addr !== e.rom_addr ||
             io_sel !== e.io_sel || led_n !== e.led_n) begin
            n_bad++;
            $display("FAIL %s: got ram %b/%h rom %b/%h io %b led_n %b, want ram %b/%h rom %b/%h io %b led_n %b",
                     e.tag, ram_sel, ram_addr, rom_sel, rom_addr, io_sel, led_n,
                     e.ram_sel, e.ram_addr, e.rom_sel, e.rom_addr, e.io_sel, e.led_n);
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout, want completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      access(1, 0, 16'h0000, 8'h00, "R7 reset map/led");
      access(1, 0, 16'h7FFF, 8'h00, "R1 lower top");
      access(1, 0, 16'h8000, 8'h00, "R2 upper base");
      access(1, 0, 16'hDFFF, 8'h00, "R2 upper top");
      access(1, 0, 16'hE000, 8'h00, "R3 io base");
      access(1, 0, 16'hEFFF, 8'h00, "R3 io top");
      access(1, 0, 16'hEF00, 8'h00, "R9 read latch addr");
      access(1, 0, 16'hF000, 8'h00, "R4 rom base");
      access(1, 0, 16'hFFEF, 8'h00, "R4 rom top");
      access(1, 0, 16'hFFF0, 8'h00, "R5 vec base");
      access(1, 0, 16'hFFFF, 8'h00, "R5 vec top");
      access(0, 0, 16'h1000, 8'h00, "R10 idle");
      access(1, 1, 16'hEF00, 8'h35, "R6 write cycle old map");
      access(1, 0, 16'h1234, 8'h00, "R6 new map 5");
      access(1, 0, 16'hF123, 8'h00, "R4 page 3 / R8 led on");
      access(1, 0, 16'hFFFE, 8'h00, "R5 vec fixed at page 7");
      access(1, 0, 16'h9ABC, 8'h00, "R2 upper ignores map");
      access(1, 1, 16'hEF00, 8'h81, "R6 write alias");
      access(1, 0, 16'h0100, 8'h00, "R2 alias lower");
      access(1, 0, 16'h8100, 8'h00, "R2 alias upper");
      access(1, 1, 16'hEF01, 8'h00, "R9 write other io");
      access(1, 0, 16'h0200, 8'h00, "R9 after other write");
      access(0, 1, 16'hEF00, 8'h00, "R9 write no valid");
      access(1, 0, 16'h0300, 8'h00, "R9 after invalid write");
      access(1, 1, 16'h4000, 8'h00, "R9 ram write");
      access(1, 0, 16'hF800, 8'h00, "R9 page kept");
      access(1, 1, 16'hEF00, 8'h7F, "R8 write led on");
      access(1, 0, 16'h7FFF, 8'h00, "R1 map 15 / R8");
      access(1, 0, 16'hFABC, 8'h00, "R4 page 7");
      access(1, 1, 16'hEF00, 8'hA6, "R8 write led off");
      access(1, 0, 16'h2345, 8'h00, "R1 map 6 / R8 off");
      access(1, 0, 16'hF001, 8'h00, "R4 page 2");
      access(0, 0, 16'hFFF5, 8'h00, "R10 idle vec / R11");
      @(negedge clk);
      bus_valid = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
   end

endmodule